// File: doc/BRIEF.md
# Branch Target Address Cache

This block guesses where a branch will go, using only the fetch address. The table is direct-mapped and has 512 entries. Each entry holds four things: a valid bit, a two-bit partial tag, a stored address, and a flag that marks the entry as belonging to a subroutine return. A lookup is combinational from the registered fetch PC, so its result is ready in the same cycle as the instruction-cache read. The lookup reports whether the entry hit, the stored address, and whether the hit was on a return entry.

Only two tag bits are kept, so the block accepts occasional false hits. An address that aliases onto a live entry yields that entry's target. When a branch resolves, the update port writes its computed target into the entry selected by the branch address. The new target replaces whatever was there before.

On a return entry, the stored value is the address of the first instruction of the called subroutine, not a jump destination. The return-hit output tells the fetch logic to take the real return address from a separate return predictor.

Top module: `btac_predictor`

## Requirements
- R1: After reset every entry is invalid, so no lookup address hits until an update has been written.
- R2: The entry is selected by address bits [10:2] and its partial tag is address bits [12:11]. A lookup hits when the selected entry is valid and its stored tag equals the lookup's bits [12:11]. On a hit, the stored address appears on the target output.
- R3: Address bits [1:0] and bits above 12 take no part in the lookup. Any two addresses that agree on bits [12:2] therefore see the same result, which includes false hits.
- R4: A lookup whose bits [10:2] select a valid entry but whose bits [12:11] differ from that entry's stored tag misses.
- R5: An update writes the tag, the address and the return flag of its entry all together. A later lookup sees only the most recent write to that entry.
- R6: The return-hit output is 1 exactly when a lookup hits an entry whose return flag was written as 1. On such a hit, the target output carries the stored subroutine-entry address.
- R7: An update aimed at the entry being looked up in the same cycle does not change that cycle's lookup result. It becomes visible from the next cycle on.
- R8: On a miss, the target output is 0 and return-hit is 0.
- R9: An update leaves every entry with a different index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Registered fetch address used for the lookup |
| lk_hit | output | 1 | Lookup hit |
| lk_target | output | 32 | Stored address on a hit, 0 on a miss |
| lk_ret_hit | output | 1 | Hit on a return entry; the real return target must come from elsewhere |
| up_en | input | 1 | Write the resolved branch into the table |
| up_pc | input | 32 | Address of the resolved branch |
| up_target | input | 32 | Computed target, or subroutine entry address for a return |
| up_is_ret | input | 1 | Marks the written entry as a return entry |

## Verification
Directed lookups follow one written entry across addresses that change only the high bits or the byte offset, which must still hit. They also cover addresses that change only the tag bits, which must miss, and the nearby index, which must stay empty. Together these separate correct index and tag selection from off-by-one slicing. A write and a lookup to the same entry in the same cycle show whether the write leaks into the current result. Overwrites with a flipped return flag show that all fields are replaced together. A long random phase over a small address window forces many collisions and rewrites. It is compared cycle by cycle against a behavioural table.

// File: rtl/btac_pkg.sv
package btac_pkg;
  parameter int ADDR_W  = 32;
  parameter int IDX_LSB = 2;
  parameter int IDX_W   = 9;
  parameter int TAG_W   = 2;
  localparam int DEPTH   = 1 << IDX_W;
  localparam int TAG_LSB = IDX_LSB + IDX_W;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    tag_t  tag;
    logic  is_ret;
    addr_t target;
  } entry_t;

  function automatic idx_t pc_index(input addr_t pc);
    return pc[TAG_LSB-1:IDX_LSB];
  endfunction

  function automatic tag_t pc_tag(input addr_t pc);
    return pc[TAG_LSB+TAG_W-1:TAG_LSB];
  endfunction
endpackage

// File: rtl/btac_store.sv
module btac_store
  import btac_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  idx_t   wr_idx,
  input  entry_t wr_entry,
  input  idx_t   rd_idx,
  output logic   rd_valid,
  output entry_t rd_entry
);
  logic [DEPTH-1:0] valid_q;
  entry_t           mem_q [DEPTH];

  // valid bits are the only reset state
  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_entry;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_entry = mem_q[rd_idx];

  // R5: a write lands whole in its slot
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_en) |-> valid_q[$past(wr_idx)] && mem_q[$past(wr_idx)] == $past(wr_entry));
endmodule

// File: rtl/btac_match.sv
module btac_match
  import btac_pkg::*;
(
  input  logic   ent_valid,
  input  entry_t ent,
  input  tag_t   look_tag,
  output logic   hit,
  output logic   ret_hit,
  output addr_t  target
);
  logic tag_eq;
  assign tag_eq  = (ent.tag == look_tag);
  assign hit     = ent_valid && tag_eq;
  assign ret_hit = hit && ent.is_ret;
  assign target  = hit ? ent.target : '0;
endmodule

// File: rtl/btac_predictor.sv
module btac_predictor
  import btac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_target,
  output logic              lk_ret_hit,
  input  logic              up_en,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic [ADDR_W-1:0] up_target,
  input  logic              up_is_ret
);
  // named internal events
  idx_t   look_idx, wr_idx;
  tag_t   look_tag;
  entry_t wr_entry, rd_entry;
  logic   rd_valid;
  logic   wr_fire;

  assign look_idx = pc_index(lk_pc);
  assign look_tag = pc_tag(lk_pc);
  assign wr_idx   = pc_index(up_pc);
  assign wr_fire  = up_en && rst_n;
  assign wr_entry = '{tag: pc_tag(up_pc), is_ret: up_is_ret, target: up_target};

  btac_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_fire),
    .wr_idx   (wr_idx),
    .wr_entry (wr_entry),
    .rd_idx   (look_idx),
    .rd_valid (rd_valid),
    .rd_entry (rd_entry)
  );

  btac_match u_match (
    .ent_valid (rd_valid),
    .ent       (rd_entry),
    .look_tag  (look_tag),
    .hit       (lk_hit),
    .ret_hit   (lk_ret_hit),
    .target    (lk_target)
  );

  // R1: first cycle out of reset sees an empty table
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !lk_hit);

  // R2: a hit only comes from a matching partial tag
  a_r2_hit_tag_match: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> rd_valid && rd_entry.tag == pc_tag(lk_pc));

  // R6: return indication only on a hit
  a_r6_ret_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ret_hit |-> lk_hit);

  // R8: a miss drives quiet outputs
  a_r8_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_target == '0 && !lk_ret_hit);

  // R7: a write is visible to the same address one cycle later
  a_r7_next_cycle_visible: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(up_en) && lk_pc == $past(up_pc)
      |-> lk_hit && lk_target == $past(up_target) && lk_ret_hit == $past(up_is_ret));
endmodule

// File: tb/btac_predictor_test.sv
module btac_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_hit;
  logic [31:0] lk_target;
  logic        lk_ret_hit;
  logic        up_en = 1'b0;
  logic [31:0] up_pc = '0;
  logic [31:0] up_target = '0;
  logic        up_is_ret = 1'b0;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // behavioural model: plain integer arrays keyed by slot number
  bit          m_valid [512];
  int unsigned m_tag   [512];
  logic [31:0] m_tgt   [512];
  bit          m_ret   [512];

  always #5 clk = ~clk;

  btac_predictor uut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
    .lk_target(lk_target), .lk_ret_hit(lk_ret_hit), .up_en(up_en),
    .up_pc(up_pc), .up_target(up_target), .up_is_ret(up_is_ret)
  );

  function automatic int unsigned slot_of(input logic [31:0] a);
    return (a / 4) % 512;
  endfunction
  function automatic int unsigned tagv_of(input logic [31:0] a);
    return (a / 2048) % 4;
  endfunction

  task automatic compare(input string req);
    int unsigned s;
    bit          eh, er;
    logic [31:0] et;
    s  = slot_of(lk_pc);
    eh = m_valid[s] && (m_tag[s] == tagv_of(lk_pc));
    er = eh && m_ret[s];
    et = eh ? m_tgt[s] : 32'h0;
    vectors++;
    if (lk_hit !== eh || lk_target !== et || lk_ret_hit !== er) begin
      errors++;
      $display("FAIL %s pc=%h actual hit=%b tgt=%h ret=%b expected hit=%b tgt=%h ret=%b",
               req, lk_pc, lk_hit, lk_target, lk_ret_hit, eh, et, er);
    end
  endtask

  // one cycle: drive at negedge, compare before the edge, then update the model
  task automatic step(input string req, input logic [31:0] pc,
                      input bit we, input logic [31:0] wpc,
                      input logic [31:0] wt, input bit wr);
    @(negedge clk);
    lk_pc = pc; up_en = we; up_pc = wpc; up_target = wt; up_is_ret = wr;
    #1;
    compare(req);
    @(posedge clk);
    if (we) begin
      m_valid[slot_of(wpc)] = 1;
      m_tag[slot_of(wpc)]   = tagv_of(wpc);
      m_tgt[slot_of(wpc)]   = wt;
      m_ret[slot_of(wpc)]   = wr;
    end
  endtask

  task automatic look(input string req, input logic [31:0] pc);
    step(req, pc, 0, 32'h0, 32'h0, 0);
  endtask

  task automatic write(input string req, input logic [31:0] wpc,
                       input logic [31:0] wt, input bit wr);
    step(req, wpc ^ 32'h4, 1, wpc, wt, wr);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      m_valid[i] = 0; m_tag[i] = 0; m_tgt[i] = '0; m_ret[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty table
    look("R1", 32'h0000_0000);
    look("R1", 32'h0000_1234);
    look("R1", 32'hFFFF_FFFC);

    // R2: basic write and hit
    write("R2", 32'h0000_1234, 32'h0000_4000, 0);
    look("R2", 32'h0000_1234);
    look("R9", 32'h0000_1238);
    // R3: aliases on high bits and byte offset
    look("R3", 32'h0000_3234);
    look("R3", 32'hABCD_1237);
    // R4: tag bits differ
    look("R4", 32'h0000_1A34);
    look("R4", 32'h0000_0234);
    // R5: overwrite with new tag and flag
    write("R5", 32'h0000_0A34, 32'h0000_8888, 1);
    look("R5", 32'h0000_1234);
    look("R6", 32'h0000_0A34);
    write("R5", 32'h0000_0A34, 32'h0000_9990, 0);
    look("R6", 32'h0000_0A34);
    // R6: return entry elsewhere
    write("R6", 32'h0000_0100, 32'h0001_0000, 1);
    look("R6", 32'h0000_0100);
    look("R8", 32'h0000_0900);
    // R7: same-cycle write and lookup to one slot
    step("R7", 32'h0000_0500, 1, 32'h0000_0500, 32'h0000_5550, 0);
    look("R7", 32'h0000_0500);
    step("R7", 32'h0000_0500, 1, 32'h0000_0500, 32'h0000_6660, 1);
    look("R7", 32'h0000_0500);
    // R9: neighbours still intact
    look("R9", 32'h0000_0104);
    look("R9", 32'h0000_0100);

    // random phase in a narrow window to force aliasing and rewrites
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b, t;
      a = {$urandom, 2'b00} & 32'h0000_3FFF;
      b = {$urandom, 2'b00} & 32'h0000_3FFF;
      if ($urandom % 4 == 0) a = b;
      if ($urandom % 8 == 0) a = a | 32'hF000_0000;
      t = $urandom;
      step("R2", a, ($urandom % 3) == 0, b, t, $urandom % 2);
    end

    // R1: reset mid-run empties the table again
    @(negedge clk);
    rst_n = 1'b0; up_en = 0;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 512; i++) m_valid[i] = 0;
    @(negedge clk);
    rst_n = 1'b1;
    look("R1", 32'h0000_0500);
    look("R1", 32'h0000_0100);

    finish_run();
  end
endmodule